// File: doc/BRIEF.md
# Reed-Solomon Syndrome Calculator with Erasure Capture

This block is the front end of a Reed-Solomon decoder over GF(256). Each byte of a received block is accepted on a valid/ready input. The first byte is the highest-order coefficient of the received polynomial. For every root the block keeps one Horner accumulator, and each accumulator is updated by one byte per clock. The roots are consecutive powers of the field generator, starting at exponent 120. The number of roots in use, R, is chosen per block at run time and can be at most 20. The solver stages downstream use the syndromes to locate and correct errors. Those stages are not part of this block.

While the bytes stream in, the block also keeps a list of the bytes that arrive with the erasure flag set. Each byte is recorded by its polynomial degree. Every pair of check bytes can pay for either one error or two erasures. The block therefore reports the total number of erasures, and flags a block whose erasures alone already exceed R. One cycle after the last byte, a single-cycle `done` strobe presents the syndromes, an all-zero flag, the erasure count, the overflow flag and the position list together. These results stay unchanged until the next `done`.

The input has no back-pressure while the block is out of reset. `in_ready` is low only while reset is applied. The source may insert idle cycles anywhere by lowering `in_valid`. A byte is taken only on a cycle where `in_valid` and `in_ready` are both high.

Top module: `rs_syndrome_calc`

## Requirements
- R1: Field arithmetic uses the reduction polynomial x^8+x^7+x^2+x+1 (reduction byte 0x87), and the generator is alpha = 0x02.
- R2: Syndrome j equals the sum over accepted bytes of d·alpha^((120+j)·deg). The byte at index k of an N-byte block has deg = N−1−k. Syndrome j appears on `syndromes[8j+7:8j]`.
- R3: `check_count` (even, 2 to 20) is sampled only with the byte that carries `in_first`; its value on later bytes of the block is ignored. Syndromes j ≥ R are reported as 0.
- R4: `done` pulses for one cycle, in the cycle after the accepted byte that carries `in_last`. All result outputs hold their values until the next `done`.
- R5: `syn_zero` is 1 at `done` exactly when all R active syndromes are zero.
- R6: A byte is an erasure when `in_erase` is high on the cycle it is accepted. `era_count` is the number of such bytes in the block.
- R7: Erasure positions are given as degrees (N−1−k). They are stored in arrival order: the i-th erasure goes in `era_positions[8i+7:8i]`. Unused slots read 0.
- R8: Only the first R erasures are recorded. `era_overflow` is 1 when `era_count` > R.
- R9: `in_ready` is 0 during reset and 1 afterwards. Cycles with `in_valid` low change no state, whatever the other inputs are.
- R10: An accepted byte with `in_first` starts a new block and discards any unfinished one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte present |
| in_ready | output | 1 | Byte can be taken |
| in_data | input | 8 | Received byte |
| in_first | input | 1 | First byte of a block |
| in_last | input | 1 | Last byte of a block |
| in_erase | input | 1 | Byte is an erasure |
| check_count | input | 5 | R, the number of syndromes for the block |
| done | output | 1 | Results valid (one-cycle pulse) |
| syndromes | output | 160 | Syndromes, 8 bits each, syndrome 0 in the low byte |
| syn_zero | output | 1 | All active syndromes are zero |
| era_count | output | 8 | Number of erasures in the block |
| era_overflow | output | 1 | Erasures exceed R |
| era_positions | output | 160 | Erasure degrees in arrival order, 8 bits each |

## Verification
The hardest cases are those where ignored inputs carry values that would damage the result if the design used them. One is a block whose erasures pass R, so that capture must stop while the count keeps rising. Another is a block abandoned halfway and restarted by a new first byte. In the gap cycles, the stimulus drives `in_first`, `in_last`, `in_erase` and data with `in_valid` low. After the first byte it changes `check_count` to a different value. It sends a twelve-byte block with six erasures at R=4, and a five-byte fragment followed by a fresh block. An independent log/antilog model predicts every syndrome, so a wrong root, a wrong degree or a stray update shows up as a mismatch at `done`.

// File: rtl/rs_syn_pkg.sv
`timescale 1ns/1ps
package rs_syn_pkg;
  localparam int SYM_W = 8;
  // low byte of the reduction polynomial x^8+x^7+x^2+x+1
  localparam logic [SYM_W-1:0] FIELD_LOW = 8'h87;

  function automatic logic [SYM_W-1:0] gf_xtime(input logic [SYM_W-1:0] a);
    return a[SYM_W-1] ? ({a[SYM_W-2:0], 1'b0} ^ FIELD_LOW) : {a[SYM_W-2:0], 1'b0};
  endfunction

  function automatic logic [SYM_W-1:0] gf_mul(input logic [SYM_W-1:0] a,
                                              input logic [SYM_W-1:0] b);
    logic [SYM_W-1:0] p;
    logic [SYM_W-1:0] x;
    p = '0;
    x = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) p = p ^ x;
      x = gf_xtime(x);
    end
    return p;
  endfunction

  function automatic logic [SYM_W-1:0] gf_alpha_pow(input int e);
    logic [SYM_W-1:0] r;
    r = 8'h01;
    for (int i = 0; i < e; i++) r = gf_xtime(r);
    return r;
  endfunction
endpackage

// File: rtl/rs_horner_cell.sv
`timescale 1ns/1ps
module rs_horner_cell
  import rs_syn_pkg::*;
#(
  parameter logic [SYM_W-1:0] ROOT = 8'h02
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             restart,
  input  logic [SYM_W-1:0] din,
  output logic [SYM_W-1:0] acc_nxt
);
  logic [SYM_W-1:0] acc_q;

  always_comb begin
    acc_nxt = (restart ? '0 : gf_mul(acc_q, ROOT)) ^ din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= '0;
    else if (step) acc_q <= acc_nxt;
  end
endmodule

// File: rtl/rs_erasure_log.sv
`timescale 1ns/1ps
module rs_erasure_log #(
  parameter int MAX_R = 20,
  parameter int IDX_W = 8,
  parameter int R_W   = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        step,
  input  logic                        restart,
  input  logic                        erase,
  input  logic [R_W-1:0]              limit,
  input  logic [IDX_W-1:0]            idx,
  output logic [IDX_W-1:0]            cnt_nxt,
  output logic [MAX_R-1:0][IDX_W-1:0] slots_nxt
);
  logic [IDX_W-1:0]            cnt_q;
  logic [IDX_W-1:0]            cnt_base;
  logic [MAX_R-1:0][IDX_W-1:0] slots_q;

  always_comb begin
    cnt_base = restart ? '0 : cnt_q;
    if (erase && (cnt_base != {IDX_W{1'b1}})) cnt_nxt = cnt_base + 1'b1;
    else                                      cnt_nxt = cnt_base;
  end

  for (genvar i = 0; i < MAX_R; i++) begin : g_slot
    always_comb begin
      slots_nxt[i] = restart ? '0 : slots_q[i];
      if (erase && (int'(cnt_base) == i) && (i < int'(limit)))
        slots_nxt[i] = idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      slots_q <= '0;
    end else if (step) begin
      cnt_q   <= cnt_nxt;
      slots_q <= slots_nxt;
    end
  end
endmodule

// File: rtl/rs_syndrome_calc.sv
`timescale 1ns/1ps
module rs_syndrome_calc
  import rs_syn_pkg::*;
#(
  parameter int MAX_R      = 20,
  parameter int FIRST_ROOT = 120,
  parameter int IDX_W      = 8,
  localparam int R_W       = $clog2(MAX_R + 1),
  localparam int VEC_W     = MAX_R * SYM_W,
  localparam int POS_W     = MAX_R * IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SYM_W-1:0] in_data,
  input  logic             in_first,
  input  logic             in_last,
  input  logic             in_erase,
  input  logic [R_W-1:0]   check_count,
  output logic             done,
  output logic [VEC_W-1:0] syndromes,
  output logic             syn_zero,
  output logic [IDX_W-1:0] era_count,
  output logic             era_overflow,
  output logic [POS_W-1:0] era_positions
);
  logic                        rdy_q;
  logic                        accept;
  logic [IDX_W-1:0]            idx_q;
  logic [IDX_W-1:0]            idx_cur;
  logic [R_W-1:0]              r_q;
  logic [R_W-1:0]              r_cur;
  logic [MAX_R-1:0][SYM_W-1:0] acc_nxt;
  logic [MAX_R-1:0][SYM_W-1:0] syn_nxt;
  logic [MAX_R-1:0][SYM_W-1:0] syn_q;
  logic [IDX_W-1:0]            cnt_nxt;
  logic [MAX_R-1:0][IDX_W-1:0] slots_nxt;
  logic [MAX_R-1:0][IDX_W-1:0] pos_nxt;
  logic [MAX_R-1:0][IDX_W-1:0] pos_q;
  logic                        done_q;
  logic                        zero_q;
  logic                        ovf_q;
  logic [IDX_W-1:0]            cnt_q;

  assign in_ready = rdy_q;
  assign accept   = in_valid && rdy_q;
  assign idx_cur  = in_first ? '0 : idx_q;
  assign r_cur    = in_first ? check_count : r_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      r_q   <= '0;
    end else if (accept) begin
      idx_q <= idx_cur + 1'b1;
      r_q   <= r_cur;
    end
  end

  for (genvar j = 0; j < MAX_R; j++) begin : g_root
    rs_horner_cell #(
      .ROOT(gf_alpha_pow(FIRST_ROOT + j))
    ) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (accept),
      .restart (in_first),
      .din     (in_data),
      .acc_nxt (acc_nxt[j])
    );
    assign syn_nxt[j] = (j < int'(r_cur)) ? acc_nxt[j] : '0;
  end

  rs_erasure_log #(
    .MAX_R (MAX_R),
    .IDX_W (IDX_W),
    .R_W   (R_W)
  ) u_log (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (accept),
    .restart   (in_first),
    .erase     (in_erase),
    .limit     (r_cur),
    .idx       (idx_cur),
    .cnt_nxt   (cnt_nxt),
    .slots_nxt (slots_nxt)
  );

  // degree of a recorded byte = index of the closing byte minus its own index
  for (genvar i = 0; i < MAX_R; i++) begin : g_pos
    assign pos_nxt[i] = ((i < int'(cnt_nxt)) && (i < int'(r_cur)))
                        ? (idx_cur - slots_nxt[i]) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      syn_q  <= '0;
      zero_q <= 1'b0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      pos_q  <= '0;
    end else begin
      done_q <= accept && in_last;
      if (accept && in_last) begin
        syn_q  <= syn_nxt;
        zero_q <= (syn_nxt == '0);
        cnt_q  <= cnt_nxt;
        ovf_q  <= (int'(cnt_nxt) > int'(r_cur));
        pos_q  <= pos_nxt;
      end
    end
  end

  assign done          = done_q;
  assign syndromes     = syn_q;
  assign syn_zero      = zero_q;
  assign era_count     = cnt_q;
  assign era_overflow  = ovf_q;
  assign era_positions = pos_q;
endmodule

// File: rtl/rs_syndrome_calc_chk.sv
`timescale 1ns/1ps
module rs_syndrome_calc_chk #(
  parameter int MAX_R = 20,
  parameter int IDX_W = 8,
  parameter int R_W   = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   in_last,
  input logic                   done,
  input logic [MAX_R*8-1:0]     syndromes,
  input logic                   syn_zero,
  input logic [IDX_W-1:0]       era_count,
  input logic                   era_overflow,
  input logic [MAX_R*IDX_W-1:0] era_positions,
  input logic [R_W-1:0]         r_sel
);
  p_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> in_ready);

  p_done_follows_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> done);

  p_done_needs_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_valid && in_ready && in_last));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(syndromes) && $stable(era_count) && $stable(era_positions)));

  p_zero_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (syn_zero == (syndromes == '0)));

  p_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (era_overflow == (int'(era_count) > int'(r_sel))));

  p_pos_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (era_count >= 2) && (r_sel >= 2)) |->
      (era_positions[IDX_W-1:0] > era_positions[2*IDX_W-1:IDX_W]));

  for (genvar j = 0; j < MAX_R; j++) begin : g_hi
    p_unused_root_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (j >= int'(r_sel))) |-> (syndromes[j*8 +: 8] == 8'h00));
  end
endmodule

bind rs_syndrome_calc rs_syndrome_calc_chk #(
  .MAX_R (MAX_R),
  .IDX_W (IDX_W),
  .R_W   (R_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .in_last       (in_last),
  .done          (done),
  .syndromes     (syndromes),
  .syn_zero      (syn_zero),
  .era_count     (era_count),
  .era_overflow  (era_overflow),
  .era_positions (era_positions),
  .r_sel         (r_q)
);

// File: tb/rs_syndrome_calc_bench.sv
`timescale 1ns/1ps
module rs_syndrome_calc_bench;
  localparam int MR = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [7:0]    in_data = '0;
  logic          in_first = 1'b0;
  logic          in_last = 1'b0;
  logic          in_erase = 1'b0;
  logic [4:0]    check_count = '0;
  logic          done;
  logic [MR*8-1:0] syndromes;
  logic          syn_zero;
  logic [7:0]    era_count;
  logic          era_overflow;
  logic [MR*8-1:0] era_positions;

  always #2.5 clk = ~clk;

  rs_syndrome_calc u_rs_syndrome_calc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_first(in_first), .in_last(in_last),
    .in_erase(in_erase), .check_count(check_count), .done(done),
    .syndromes(syndromes), .syn_zero(syn_zero), .era_count(era_count),
    .era_overflow(era_overflow), .era_positions(era_positions)
  );

  int n_checks = 0;
  int n_err    = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // log/antilog tables for the field (R1: reduction byte 0x87, alpha = 0x02)
  int gexp [0:254];
  int glog [0:255];
  initial begin
    int v;
    v = 1;
    for (int e = 0; e < 255; e++) begin
      gexp[e] = v;
      glog[v] = e;
      v = v << 1;
      if (v > 255) v = (v & 255) ^ 'h87;
    end
  end

  function automatic int term(input int d, input int e);
    if (d == 0) return 0;
    return gexp[(glog[d] + e) % 255];
  endfunction

  typedef struct {
    int syn [MR];
    int pos [MR];
    bit zero;
    int cnt;
    bit ovf;
    int r;
    bit r1_case;
  } exp_t;

  exp_t sb [$];
  int   bd [0:255];
  bit   be [0:255];
  int unsigned seed = 32'h1234_5678;
  int   last_syn0;
  int   last_cnt;

  function automatic int rnd8();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return int'(seed[23:16]);
  endfunction

  task automatic send_block(input int n, input int r, input bit gap, input bit r1c);
    exp_t e;
    int c;
    e.r = r;
    e.r1_case = r1c;
    e.zero = 1'b1;
    for (int j = 0; j < MR; j++) begin
      int s;
      s = 0;
      if (j < r)
        for (int k = 0; k < n; k++) s = s ^ term(bd[k], ((120 + j) * (n - 1 - k)) % 255);
      e.syn[j] = s;
      if (s != 0) e.zero = 1'b0;
      e.pos[j] = 0;
    end
    c = 0;
    for (int k = 0; k < n; k++)
      if (be[k]) begin
        if (c < r) e.pos[c] = n - 1 - k;
        c++;
      end
    e.cnt = c;
    e.ovf = (c > r);
    sb.push_back(e);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid    = 1'b1;
      in_data     = 8'(bd[k]);
      in_first    = (k == 0);
      in_last     = (k == n - 1);
      in_erase    = be[k];
      check_count = (k == 0) ? 5'(r) : 5'd2;   // R3: later values must be ignored
      if (gap && k < n - 1) begin
        @(negedge clk);
        in_valid = 1'b0;                         // R9: garbage while idle
        in_first = 1'b1;
        in_last  = 1'b1;
        in_erase = 1'b1;
        in_data  = 8'hFF;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_first = 1'b0;
    in_last  = 1'b0;
    in_erase = 1'b0;
  endtask

  task automatic send_fragment(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid    = 1'b1;
      in_data     = 8'(rnd8());
      in_first    = (k == 0);
      in_last     = 1'b0;
      in_erase    = 1'b1;
      check_count = 5'd20;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_erase = 1'b0;
  endtask

  task automatic clear_block(input int n);
    for (int k = 0; k < n; k++) begin
      bd[k] = 0;
      be[k] = 1'b0;
    end
  endtask

  // monitor: scoreboard comparison at each done
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R4 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        for (int j = 0; j < MR; j++) begin
          int a;
          a = int'(syndromes[j*8 +: 8]);
          if (j >= e.r)       chk(a == e.syn[j], "R3 unused syndrome", a, e.syn[j]);
          else if (e.r1_case) chk(a == e.syn[j], "R1 root power", a, e.syn[j]);
          else                chk(a == e.syn[j], "R2 syndrome", a, e.syn[j]);
        end
        chk(syn_zero == e.zero, "R5 zero flag", int'(syn_zero), int'(e.zero));
        chk(int'(era_count) == e.cnt, "R6 erasure count", int'(era_count), e.cnt);
        chk(era_overflow == e.ovf, "R8 overflow", int'(era_overflow), int'(e.ovf));
        for (int i = 0; i < MR; i++) begin
          int a;
          a = int'(era_positions[i*8 +: 8]);
          chk(a == e.pos[i], "R7 position", a, e.pos[i]);
        end
        last_syn0 = int'(syndromes[7:0]);
        last_cnt  = int'(era_count);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b0, "R9 ready in reset", int'(in_ready), 0);
    chk(done == 1'b0, "R4 reset done", int'(done), 0);
    chk(syndromes == '0, "R2 reset syndromes", int'(syndromes[7:0]), 0);
    chk(era_count == 8'd0, "R6 reset count", int'(era_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R9 ready after reset", int'(in_ready), 1);

    // R5: all-zero block, every root active
    clear_block(10);
    send_block(10, 20, 1'b0, 1'b0);

    // R1: single 1 at degree 1 -> syndrome j = alpha^(120+j)
    clear_block(3);
    bd[1] = 1;
    send_block(3, 20, 1'b0, 1'b1);

    // R3: constant at degree 0, only 4 roots active
    clear_block(3);
    bd[2] = 'h5A;
    send_block(3, 4, 1'b0, 1'b0);

    // R2/R6/R7: random data, erasures at first, middle, last bytes
    clear_block(40);
    for (int k = 0; k < 40; k++) bd[k] = rnd8();
    be[0] = 1'b1; be[7] = 1'b1; be[39] = 1'b1;
    send_block(40, 20, 1'b0, 1'b0);

    // R8: six erasures with R = 4
    clear_block(12);
    for (int k = 0; k < 12; k++) bd[k] = rnd8();
    for (int k = 1; k <= 6; k++) be[k] = 1'b1;
    send_block(12, 4, 1'b0, 1'b0);

    // R4: results hold while idle
    repeat (4) @(negedge clk);
    chk(done == 1'b0, "R4 done is a pulse", int'(done), 0);
    chk(int'(syndromes[7:0]) == last_syn0, "R4 hold syndromes", int'(syndromes[7:0]), last_syn0);
    chk(int'(era_count) == last_cnt, "R4 hold count", int'(era_count), last_cnt);

    // R9: idle cycles with garbage between every byte
    clear_block(20);
    for (int k = 0; k < 20; k++) bd[k] = rnd8();
    be[3] = 1'b1; be[11] = 1'b1;
    send_block(20, 8, 1'b1, 1'b0);

    // R10: abandoned fragment, then a fresh block
    send_fragment(5);
    clear_block(15);
    for (int k = 0; k < 15; k++) bd[k] = rnd8();
    be[14] = 1'b1;
    send_block(15, 6, 1'b0, 1'b0);

    // R2: longest block, smallest R
    clear_block(255);
    for (int k = 0; k < 255; k++) bd[k] = rnd8();
    be[100] = 1'b1;
    send_block(255, 2, 1'b0, 1'b0);

    repeat (5) @(negedge clk);
    chk(sb.size() == 0, "R4 missing done", sb.size(), 0);
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule